// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the SDRAM command pins from reset onward. It holds the bus in a no-operation state for a programmable pause, closes every bank, runs a burst of auto-refresh cycles and writes the mode register with a word built from parameters. After that it keeps the array alive by issuing periodic auto-refreshes. Every refresh is preceded by a precharge-all, because refresh is only legal with all banks idle.

A downstream access engine asks for the bus with `acc_req`. It receives `acc_grant` once initialization has finished, no refresh is owed and the last refresh interval has elapsed. It keeps the grant for as long as it holds its request. While the grant is held, this block drives only NOP on its pins. A refresh that falls due during a grant is counted, not forced. It blocks the next grant and runs as soon as the engine releases the bus. All spacings are parameters counted in clock cycles.

Top module: `sdram_cmd_seq`

## Requirements
Commands are read as {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge-all = 0010, auto-refresh = 0001, mode set = 0000. Cycle n means the value visible after the n-th rising edge following reset release.
- R1: During reset and right after it, the outputs show NOP, cke is 1, addr and ba are 0, and init_done, acc_grant and ref_busy are 0.
- R2: The first command other than NOP is a precharge-all at cycle T_PAUSE+1, with addr = 0x400 (A10 high) and ba = 0.
- R3: Exactly N_INIT_REF auto-refreshes follow during initialization. The first comes T_RP cycles after the precharge-all and each later one comes T_RC cycles after the previous one. No other command appears in between.
- R4: A mode set follows T_RC cycles after the last initial refresh. Its addr carries A6..A4 = CAS latency (010 = 2, 011 = 3), A3 = burst type (0 sequential, 1 interleave) and A2..A0 = burst length (001 = 2, 010 = 4, 011 = 8). A11..A7 and ba are 0.
- R5: init_done rises exactly T_MRD cycles after the mode set and never falls until reset.
- R6: After init_done, one refresh becomes owed every T_REFI cycles. Each owed refresh is served by a precharge-all followed T_RP cycles later by an auto-refresh.
- R7: acc_grant is never asserted before init_done. It rises one cycle after acc_req is seen high while the sequencer is idle with nothing owed. It stays high while acc_req stays high. No command other than NOP is driven while it is high.
- R8: An owed refresh does not take the bus from an active grant. It does block any new grant until the refresh and its T_RC recovery are complete.
- R9: The count of owed refreshes saturates at PEND_MAX. After release, all owed refreshes run back to back behind a single precharge-all, spaced T_RC apart.
- R10: ref_busy rises in the cycle the sequencer commits to a refresh, before its precharge-all. It falls T_RC cycles after the last auto-refresh of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access engine asks for the bus |
| acc_grant | output | 1 | Bus granted to the access engine |
| init_done | output | 1 | Power-up sequence complete |
| ref_busy | output | 1 | Refresh run in progress |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Address pins |
| ba | output | 2 | Bank select pins |

## Verification
A wrong count of remaining initial refreshes shows up at the pins within one refresh interval: the mode set appears T_RC early or late, or an extra refresh appears. A wrong owed-refresh count shows up after the next grant release as too many or too few back-to-back refreshes. A premature grant shows up within a cycle as acc_grant high together with ref_busy or before init_done. Bad spacing counters show up as a command arriving before its predecessor's recovery window has closed. This is visible at the very next command.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int T_PAUSE    = 20000,
  parameter int T_RP       = 3,
  parameter int T_RC       = 9,
  parameter int T_MRD      = 3,
  parameter int N_INIT_REF = 8,
  parameter int T_REFI     = 1562,
  parameter int PEND_MAX   = 7,
  parameter int CAS_LAT    = 3,
  parameter int BURST_LEN  = 8,
  parameter bit BURST_INTERLEAVE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_req,
  output logic        acc_grant,
  output logic        init_done,
  output logic        ref_busy,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [11:0] addr,
  output logic [1:0]  ba
);
  localparam int TM1  = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int TM2  = (TM1 > T_MRD) ? TM1 : T_MRD;
  localparam int TMAX = (T_PAUSE > TM2) ? T_PAUSE : TM2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(T_REFI);
  localparam int PW   = $clog2(PEND_MAX + 1);
  localparam int IW   = $clog2(N_INIT_REF + 1);
  localparam logic [2:0]  CL_CODE   = 3'(CAS_LAT);
  localparam logic [2:0]  BL_CODE   = 3'($clog2(BURST_LEN));
  localparam logic [11:0] MODE_WORD = {5'b0, CL_CODE, BURST_INTERLEAVE, BL_CODE};
  localparam logic [3:0] C_NOP = 4'b0111, C_PREA = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  typedef enum logic [2:0] {S_PREA, S_REF, S_MRS, S_DONE, S_IDLE, S_GRANT} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] init_left;
  logic [RW-1:0] refi;
  logic [PW-1:0] pending, pend_nx;
  logic [3:0]    cmd_q;
  logic          tick, dec;

  assign cke = 1'b1;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign tick = init_done && (refi == RW'(T_REFI - 1));
  assign dec  = init_done && (state == S_REF) && (cnt == '0);

  always_comb begin
    pend_nx = pending;
    if (dec) pend_nx = pend_nx - 1'b1;
    if (tick && pend_nx != PW'(PEND_MAX)) pend_nx = pend_nx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refi    <= '0;
      pending <= '0;
    end else begin
      pending <= pend_nx;
      if (init_done) refi <= tick ? '0 : refi + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_PREA;
      cnt       <= CW'(T_PAUSE);
      init_left <= IW'(N_INIT_REF);
      cmd_q     <= C_NOP;
      addr      <= '0;
      ba        <= '0;
      init_done <= 1'b0;
      acc_grant <= 1'b0;
      ref_busy  <= 1'b0;
    end else begin
      cmd_q <= C_NOP;
      addr  <= '0;
      ba    <= '0;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (state)
          S_PREA: begin
            cmd_q <= C_PREA;
            addr  <= 12'h400;
            cnt   <= CW'(T_RP - 1);
            state <= S_REF;
          end
          S_REF: begin
            cmd_q <= C_REF;
            cnt   <= CW'(T_RC - 1);
            if (!init_done) begin
              init_left <= init_left - 1'b1;
              state     <= (init_left == IW'(1)) ? S_MRS : S_REF;
            end else begin
              state <= (pend_nx != '0) ? S_REF : S_IDLE;
            end
          end
          S_MRS: begin
            cmd_q <= C_MRS;
            addr  <= MODE_WORD;
            cnt   <= CW'(T_MRD - 1);
            state <= S_DONE;
          end
          S_DONE: begin
            init_done <= 1'b1;
            state     <= S_IDLE;
          end
          S_IDLE: begin
            ref_busy <= (pending != '0);
            if (pending != '0) begin
              state <= S_PREA;
            end else if (acc_req) begin
              acc_grant <= 1'b1;
              state     <= S_GRANT;
            end
          end
          S_GRANT: begin
            if (!acc_req) begin
              acc_grant <= 1'b0;
              ref_busy  <= (pending != '0);
              state     <= (pending != '0) ? S_PREA : S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module sdram_cmd_seq_chk #(
  parameter int T_RP  = 3,
  parameter int T_RC  = 9,
  parameter int T_MRD = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [11:0] addr,
  input logic [1:0]  ba,
  input logic        acc_grant,
  input logic        init_done,
  input logic        ref_busy
);
  localparam logic [3:0] K_NOP = 4'b0111, K_PREA = 4'b0010, K_REF = 4'b0001, K_MRS = 4'b0000;
  logic [3:0]  cmd, last;
  logic [15:0] gap;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last <= K_NOP;
      gap  <= '0;
    end else if (cmd != K_NOP) begin
      last <= cmd;
      gap  <= 16'd1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 1'b1;
    end
  end

  assert_ref_after_prea_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_REF && last == K_PREA) |-> gap >= 16'(T_RP));
  assert_after_ref_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == K_REF || cmd == K_MRS) && last == K_REF) |-> gap >= 16'(T_RC));
  assert_mode_high_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_MRS) |-> (addr[11:7] == 5'd0 && ba == 2'd0));
  assert_done_after_mrd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (last == K_MRS && gap >= 16'(T_MRD)));
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(init_done));
  assert_no_early_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !acc_grant);
  assert_quiet_when_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> cmd == K_NOP);
  assert_grant_vs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_grant && ref_busy));
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .addr(addr), .ba(ba), .acc_grant(acc_grant), .init_done(init_done), .ref_busy(ref_busy));

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
  localparam int CLK_P = 10;
  localparam int LOGN  = 700;
  localparam logic [3:0] NOP = 4'b0111, PREA = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, acc_req = 1'b0;
  logic acc_grant, init_done, ref_busy, cke, cs_n, ras_n, cas_n, we_n;
  logic [11:0] addr;
  logic [1:0]  ba;
  int cyc = 0, checks = 0, fails = 0;
  logic [3:0]  cmd_log [LOGN];
  logic [11:0] addr_log [LOGN];
  logic [1:0]  ba_log [LOGN];
  logic        gnt_log [LOGN], busy_log [LOGN], done_log [LOGN];

  sdram_cmd_seq #(.T_PAUSE(20), .T_RP(3), .T_RC(9), .T_MRD(3), .N_INIT_REF(8),
    .T_REFI(60), .PEND_MAX(3), .CAS_LAT(2), .BURST_LEN(4), .BURST_INTERLEAVE(1'b1))
  u_sdram_cmd_seq (.clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_grant(acc_grant),
    .init_done(init_done), .ref_busy(ref_busy), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && cyc < LOGN) begin
    cmd_log[cyc] = {cs_n, ras_n, cas_n, we_n};
    addr_log[cyc] = addr;  ba_log[cyc] = ba;
    gnt_log[cyc] = acc_grant;  busy_log[cyc] = ref_busy;  done_log[cyc] = init_done;
  end

  // Expected command walk: R2 precharge, R3 init refreshes, R4 mode set,
  // R6 periodic service, R8 service after release, R9 saturated back-to-back run.
  localparam int EN = 20;
  localparam int EXP_CYC [EN] = '{21, 24, 33, 42, 51, 60, 69, 78, 87, 96,
                                  161, 164, 221, 224, 301, 304, 531, 534, 543, 552};
  localparam logic [3:0] EXP_CMD [EN] = '{PREA, REF, REF, REF, REF, REF, REF, REF, REF, MRS,
                                         PREA, REF, PREA, REF, PREA, REF, PREA, REF, REF, REF};
  localparam int EXP_REQ [EN] = '{2, 3, 3, 3, 3, 3, 3, 3, 3, 4, 6, 6, 6, 6, 8, 8, 9, 9, 9, 9};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic at_cycle(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 3000);
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=600", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cs_n, ras_n, cas_n, we_n} == NOP && cke && addr == 0 && ba == 0 &&
        !init_done && !acc_grant && !ref_busy, "R1 reset outputs",
        {cke, init_done, acc_grant, ref_busy, cs_n, ras_n, cas_n, we_n}, 8'b1000_0111);
    rst_n = 1'b1;
    at_cycle(50);  acc_req = 1'b1;
    at_cycle(90);  acc_req = 1'b0;
    at_cycle(236); acc_req = 1'b1;
    at_cycle(299); acc_req = 1'b0;
    at_cycle(301); acc_req = 1'b1;
    at_cycle(529); acc_req = 1'b0;
    at_cycle(600);

    for (int i = 0; i < EN; i++)
      chk(cmd_log[EXP_CYC[i]] == EXP_CMD[i], $sformatf("R%0d command at cycle %0d", EXP_REQ[i], EXP_CYC[i]),
          cmd_log[EXP_CYC[i]], EXP_CMD[i]);

    begin
      int n_cmd = 0;
      for (int c = 1; c < 99; c++) if (cmd_log[c] != NOP) n_cmd++;
      chk(n_cmd == 10, "R3 command count during init", n_cmd, 10);
    end
    chk(cmd_log[1] == NOP && cmd_log[20] == NOP, "R2 pause holds NOP", cmd_log[20], NOP);
    chk(addr_log[21] == 12'h400 && ba_log[21] == 0, "R2 precharge-all address", addr_log[21], 12'h400);
    chk(addr_log[96] == 12'h02A && ba_log[96] == 0, "R4 mode word CL2 interleave BL4", addr_log[96], 12'h02A);
    chk(!done_log[98] && done_log[99], "R5 init_done edge", {done_log[98], done_log[99]}, 2'b01);
    begin
      bit stay = 1'b1;
      for (int c = 99; c < 600; c++) if (!done_log[c]) stay = 1'b0;
      chk(stay, "R5 init_done stays high", stay, 1);
    end
    begin
      bit any = 1'b0;
      for (int c = 1; c < 99; c++) if (gnt_log[c]) any = 1'b1;
      chk(!any, "R7 no grant before init", any, 0);
    end
    chk(!gnt_log[236] && gnt_log[237], "R7 grant rise", {gnt_log[236], gnt_log[237]}, 2'b01);
    begin
      int n_cmd = 0;
      for (int c = 238; c < 300; c++) if (cmd_log[c] != NOP) n_cmd++;
      chk(n_cmd == 0 && gnt_log[299], "R8 owed refresh waits for release", n_cmd, 0);
    end
    chk(!gnt_log[300], "R7 grant drops on release", gnt_log[300], 0);
    chk(!gnt_log[312] && gnt_log[313], "R8 grant after refresh recovery", {gnt_log[312], gnt_log[313]}, 2'b01);
    begin
      int n_ref = 0, n_pre = 0;
      for (int c = 531; c < 579; c++) begin
        if (cmd_log[c] == REF) n_ref++;
        if (cmd_log[c] == PREA) n_pre++;
      end
      chk(n_ref == 3, "R9 saturated refresh count", n_ref, 3);
      chk(n_pre == 1, "R9 single precharge for run", n_pre, 1);
    end
    chk(busy_log[160] && !busy_log[159] && busy_log[172] && !busy_log[173],
        "R10 ref_busy window periodic", {busy_log[159], busy_log[160], busy_log[172], busy_log[173]}, 4'b0110);
    chk(!busy_log[529] && busy_log[530] && busy_log[560] && !busy_log[561],
        "R10 ref_busy window after release", {busy_log[529], busy_log[530], busy_log[560], busy_log[561]}, 4'b0110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule